// File: doc/BRIEF.md
# Two-Wire Slave with Pointer-Selected Sensor Registers

This block is the serial front end of a temperature-monitor tile. It listens on an oversampled two-wire bus, answers one 7-bit address, and selects one of four registers through a 2-bit pointer. The registers are a read-only temperature word, an 8-bit configuration byte, and two 16-bit alarm limits (upper trip and hysteresis). A bus master sets the pointer with the first data byte of a write, and may then write one or two data bytes. It can also issue a repeated START and read the selected register. A read with no pointer set first uses whatever pointer is already stored.

On the local side, the block takes converter samples through a load strobe and scales them to the resolution set in the configuration byte. While a temperature read is shifting out, it refuses new samples. It presents all register contents to the neighbouring alarm logic, and it raises a one-cycle strobe each time a register read completes, which the alarm logic uses to clear a latched interrupt. The bus is sampled by the block clock through a synchronizer. The block pulls SDA low through an open-drain enable and never drives it high.

Top module: `smbs_ptr_slave`

## Requirements
- R1: After reset the configuration byte is 0x00, the upper limit is 0x5000, the hysteresis limit is 0x4B00, the temperature word is 0x0000, the pointer selects temperature, and SDA is released.
- R2: The block responds only to the address whose upper four bits are 1001 and whose lower three bits equal addr_pins. It acknowledges by pulling SDA low during the ninth clock. Any other address gets no acknowledge.
- R3: The first data byte of a write is the pointer. If its six upper bits are zero, the byte is acknowledged and its two low bits become the pointer (00 temperature, 01 configuration, 10 hysteresis, 11 upper limit). Otherwise the byte is not acknowledged, the pointer is unchanged and the transaction is dropped.
- R4: The pointer is kept between transactions, and a read that starts without a pointer write returns the register it selects.
- R5: A configuration write takes one data byte. Bit 7 always reads as zero. The field layout is shutdown at bit 0, alarm mode at bit 1, alarm polarity at bit 2, fault count at bits 4:3 and resolution code at bits 6:5.
- R6: A limit write takes two data bytes, high byte first, each acknowledged. The four low bits of both limits always read as zero.
- R7: A data byte written while the pointer selects temperature is not acknowledged, and the temperature word is unchanged.
- R8: A configuration read returns one byte. Any other read returns two bytes, high first, and the block releases SDA during the master's acknowledge slot.
- R9: A sample load stores the sample with all bits below the top 9+r zeroed, where r is the resolution code (bits 6:5 of the configuration byte).
- R10: A sample that arrives while a temperature read is shifting out is discarded. The next sample outside a read is stored.
- R11: Each completed register read (the master's acknowledge slot after the last byte) produces a read strobe exactly one clock long.
- R12: A START or repeated START in any state restarts address reception, and an unfinished limit write is then discarded. A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 3 | Strapped low three address bits |
| sample_ld | input | 1 | Converter sample valid strobe |
| sample_val | input | 16 | Converter sample, two's complement, left aligned |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_o | output | 8 | Configuration byte |
| tos_o | output | 16 | Upper trip limit |
| thyst_o | output | 16 | Hysteresis limit |
| temp_o | output | 16 | Stored temperature word |
| rd_strobe | output | 1 | One-cycle pulse on each completed read |

## Verification
A table of writes with read-back is run against both single-byte and two-byte registers. The data patterns set the reserved configuration bit and the low limit nibble, so they tell a correct mask apart from a passthrough. Reads are issued both after a pointer write with a repeated START and from the stored pointer, which separates pointer retention from pointer update. Rejected pointers, a wrong address, a data write to the read-only word and a repeated START inside a limit write each check that nothing changed. Samples are loaded under all four resolution codes and once in the middle of a temperature read, which tells correct rounding and read-time blocking apart from a plain load.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

  typedef enum logic [1:0] {
    PTR_TEMP  = 2'b00,
    PTR_CFG   = 2'b01,
    PTR_THYST = 2'b10,
    PTR_TOS   = 2'b11
  } ptr_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RMACK, ST_RNEXT
  } st_e;

  // keeps the top 9+r bits of a left-aligned sample
  function automatic logic [15:0] res_mask(input logic [1:0] r);
    return ~(16'h007F >> r);
  endfunction

  function automatic logic ptr_ok(input logic [7:0] b);
    return b[7:2] == 6'd0;
  endfunction

  function automatic logic two_byte(input ptr_e p);
    return p != PTR_CFG;
  endfunction

endpackage

// File: rtl/smbs_line_sync.sv
module smbs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smbs_regfile.sv
module smbs_regfile
  import smbs_pkg::*;
#(
  parameter logic [15:0] TOS_RST   = 16'h5000,
  parameter logic [15:0] THYST_RST = 16'h4B00,
  parameter int          ZERO_LSBS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        tos_we,
  input  logic        thy_we,
  input  logic [15:0] wdata,
  input  logic        temp_ld,
  input  logic [15:0] temp_in,
  output logic [7:0]  cfg_o,
  output logic [15:0] tos_o,
  output logic [15:0] thyst_o,
  output logic [15:0] temp_o
);
  localparam logic [15:0] LIM_MASK = 16'hFFFF << ZERO_LSBS;
  localparam logic [7:0]  CFG_MASK = 8'h7F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o   <= '0;
      tos_o   <= TOS_RST & LIM_MASK;
      thyst_o <= THYST_RST & LIM_MASK;
      temp_o  <= '0;
    end else begin
      if (cfg_we)  cfg_o   <= wdata[7:0] & CFG_MASK;
      if (tos_we)  tos_o   <= wdata & LIM_MASK;
      if (thy_we)  thyst_o <= wdata & LIM_MASK;
      if (temp_ld) temp_o  <= temp_in & res_mask(cfg_o[6:5]);
    end
  end
endmodule

// File: rtl/smbs_ptr_slave.sv
module smbs_ptr_slave
  import smbs_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  ADDR_HI     = 4'b1001,
  parameter logic [15:0] TOS_RST     = 16'h5000,
  parameter logic [15:0] THYST_RST   = 16'h4B00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  addr_pins,
  input  logic        sample_ld,
  input  logic [15:0] sample_val,
  output logic        sda_pull,
  output logic [7:0]  cfg_o,
  output logic [15:0] tos_o,
  output logic [15:0] thyst_o,
  output logic [15:0] temp_o,
  output logic        rd_strobe
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  st_e        st;
  ptr_e       ptr;
  logic [2:0] cnt;
  logic [7:0] shreg, hold_hi, rx_byte, byte0;
  logic       rw, bsel;
  logic       cfg_we, tos_we, thy_we, temp_busy, temp_ld, byte_done;
  logic [15:0] wdata, sel_word;

  smbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign rx_byte   = {shreg[6:0], sda_s};
  assign byte_done = scl_rise && (cnt == LAST_BIT) && (st == ST_WDAT);
  assign cfg_we    = byte_done && (ptr == PTR_CFG);
  assign tos_we    = byte_done && (ptr == PTR_TOS) && bsel;
  assign thy_we    = byte_done && (ptr == PTR_THYST) && bsel;
  assign wdata     = (ptr == PTR_CFG) ? {8'h00, rx_byte} : {hold_hi, rx_byte};
  assign temp_busy = (ptr == PTR_TEMP) &&
                     (st == ST_RDAT || st == ST_RMACK || st == ST_RNEXT);
  assign temp_ld   = sample_ld && !temp_busy;

  always_comb begin
    unique case (ptr)
      PTR_TEMP:  sel_word = temp_o;
      PTR_CFG:   sel_word = {8'h00, cfg_o};
      PTR_THYST: sel_word = thyst_o;
      default:   sel_word = tos_o;
    endcase
  end
  assign byte0 = (ptr == PTR_CFG) ? cfg_o : sel_word[15:8];

  smbs_regfile #(.TOS_RST(TOS_RST), .THYST_RST(THYST_RST), .ZERO_LSBS(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tos_we(tos_we), .thy_we(thy_we),
    .wdata(wdata), .temp_ld(temp_ld), .temp_in(sample_val),
    .cfg_o(cfg_o), .tos_o(tos_o), .thyst_o(thyst_o), .temp_o(temp_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ptr <= PTR_TEMP; cnt <= '0; shreg <= '0; hold_hi <= '0;
      rw <= 1'b0; bsel <= 1'b0; sda_pull <= 1'b0; rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= 1'b0;
      if (start_evt) begin
        st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            shreg <= rx_byte; cnt <= cnt + 3'd1;
            if (cnt == LAST_BIT) begin
              if (rx_byte[7:1] == {ADDR_HI, addr_pins}) begin
                rw <= rx_byte[0]; st <= ST_AACK;
              end else st <= ST_IDLE;
            end
          end
          ST_AACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else if (rw) begin
              bsel <= 1'b0; shreg <= byte0; sda_pull <= ~byte0[7];
              cnt <= '0; st <= ST_RDAT;
            end else begin
              sda_pull <= 1'b0; cnt <= '0; st <= ST_PTR;
            end
          end
          ST_PTR: if (scl_rise) begin
            shreg <= rx_byte; cnt <= cnt + 3'd1;
            if (cnt == LAST_BIT) begin
              if (ptr_ok(rx_byte)) begin
                ptr <= ptr_e'(rx_byte[1:0]); st <= ST_PACK;
              end else st <= ST_IDLE;
            end
          end
          ST_PACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              sda_pull <= 1'b0; cnt <= '0; bsel <= 1'b0; st <= ST_WDAT;
            end
          end
          ST_WDAT: if (scl_rise) begin
            shreg <= rx_byte; cnt <= cnt + 3'd1;
            if (cnt == LAST_BIT) begin
              if (ptr == PTR_TEMP) st <= ST_IDLE;
              else begin
                if (!bsel) hold_hi <= rx_byte;
                st <= ST_WACK;
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              sda_pull <= 1'b0;
              if (two_byte(ptr) && !bsel) begin
                bsel <= 1'b1; cnt <= '0; st <= ST_WDAT;
              end else st <= ST_IDLE;
            end
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_pull <= 1'b0; st <= ST_RMACK;
            end else begin
              cnt <= cnt + 3'd1; shreg <= {shreg[6:0], 1'b0}; sda_pull <= ~shreg[6];
            end
          end
          ST_RMACK: if (scl_rise) begin
            if (!two_byte(ptr) || bsel) begin
              rd_strobe <= 1'b1; st <= ST_IDLE;
            end else if (sda_s) st <= ST_IDLE;
            else st <= ST_RNEXT;
          end
          ST_RNEXT: if (scl_fall) begin
            bsel <= 1'b1; shreg <= sel_word[7:0]; sda_pull <= ~sel_word[7];
            cnt <= '0; st <= ST_RDAT;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbs_chk.sv
module smbs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_pull,
  input logic        rd_strobe,
  input logic        scl_rise_w,
  input logic        scl_fall_w,
  input logic        start_w,
  input logic        stop_w,
  input logic        temp_busy_w,
  input logic        cfg_we_w,
  input logic [7:0]  cfg_o,
  input logic [15:0] temp_o
);
  // R12
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_pull);
  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_pull);
  // R12
  bus_event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_w, stop_w, scl_rise_w, scl_fall_w}));
  // R8
  sda_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall_w || start_w || stop_w) |=> $stable(sda_pull));
  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);
  // R11
  strobe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(scl_rise_w));
  // R10
  temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_busy_w |=> $stable(temp_o));
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_w |=> $stable(cfg_o));
endmodule

bind smbs_ptr_slave smbs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .rd_strobe(rd_strobe),
  .scl_rise_w(scl_rise), .scl_fall_w(scl_fall), .start_w(start_evt),
  .stop_w(stop_evt), .temp_busy_w(temp_busy), .cfg_we_w(cfg_we),
  .cfg_o(cfg_o), .temp_o(temp_o)
);

// File: tb/sim_smbs_ptr_slave.sv
`timescale 1ns/1ps
module sim_smbs_ptr_slave;
  localparam int HP = 10;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] AW = {4'b1001, PINS, 1'b0};
  localparam logic [7:0] AR = {4'b1001, PINS, 1'b1};

  // {pointer, written value, expected read-back}
  localparam logic [33:0] VEC [7] = '{
    {2'b01, 16'h00A5, 16'h0025},
    {2'b11, 16'h1234, 16'h1230},
    {2'b10, 16'hFFFF, 16'hFFF0},
    {2'b11, 16'h8008, 16'h8000},
    {2'b10, 16'h0007, 16'h0000},
    {2'b01, 16'h007F, 16'h007F},
    {2'b01, 16'h0000, 16'h0000}
  };

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, sample_ld = 0;
  logic [15:0] sample_val = '0;
  logic sda_pull, rd_strobe;
  logic [7:0] cfg_o;
  logic [15:0] tos_o, thyst_o, temp_o;
  wire sda_line = sda_m & ~sda_pull;
  int nchk = 0, nerr = 0, strobes = 0;

  always #2.5 clk = ~clk;

  smbs_ptr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_pins(PINS),
    .sample_ld(sample_ld), .sample_val(sample_val), .sda_pull(sda_pull),
    .cfg_o(cfg_o), .tos_o(tos_o), .thyst_o(thyst_o), .temp_o(temp_o),
    .rd_strobe(rd_strobe)
  );

  always @(negedge clk) if (rst_n && rd_strobe) strobes++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; wt(HP); scl_m = 1; wt(HP); sda_m = 0; wt(HP); scl_m = 0; wt(HP);
  endtask

  task automatic bus_stop();
    sda_m = 0; wt(HP); scl_m = 1; wt(HP); sda_m = 1; wt(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HP); scl_m = 1; wt(HP); scl_m = 0;
    end
    sda_m = 1; wt(HP); scl_m = 1; wt(HP/2);
    ack = ~sda_line;
    wt(HP/2); scl_m = 0;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(HP); scl_m = 1; wt(HP/2); b[i] = sda_line; wt(HP/2); scl_m = 0;
    end
    sda_m = last; wt(HP); scl_m = 1; wt(HP); scl_m = 0; sda_m = 1;
  endtask

  task automatic write_reg(input logic [1:0] p, input logic [15:0] d);
    logic a;
    bus_start();
    send_byte(AW, a); chk("R2 address ack", 16'(a), 16'd1);
    send_byte({6'd0, p}, a); chk("R3 pointer ack", 16'(a), 16'd1);
    if (p == 2'b01) begin
      send_byte(d[7:0], a); chk("R5 config byte ack", 16'(a), 16'd1);
    end else begin
      send_byte(d[15:8], a); chk("R6 high byte ack", 16'(a), 16'd1);
      send_byte(d[7:0], a);  chk("R6 low byte ack", 16'(a), 16'd1);
    end
    bus_stop();
  endtask

  task automatic read_reg(input logic set_ptr, input logic [1:0] p,
                          input logic two, output logic [15:0] d);
    logic a;
    logic [7:0] hi, lo;
    bus_start();
    if (set_ptr) begin
      send_byte(AW, a);
      send_byte({6'd0, p}, a);
      bus_start();
    end
    send_byte(AR, a); chk("R2 read address ack", 16'(a), 16'd1);
    if (two) begin
      recv_byte(1'b0, hi); recv_byte(1'b1, lo); d = {hi, lo};
    end else begin
      recv_byte(1'b1, lo); d = {8'h00, lo};
    end
    bus_stop();
  endtask

  task automatic load_sample(input logic [15:0] v);
    sample_val = v; sample_ld = 1; wt(1); sample_ld = 0; wt(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic a;
    int s0;
    wt(5); rst_n = 1; wt(5);
    // R1 reset state
    chk("R1 cfg", 16'(cfg_o), 16'h0000);
    chk("R1 tos", tos_o, 16'h5000);
    chk("R1 thyst", thyst_o, 16'h4B00);
    chk("R1 temp", temp_o, 16'h0000);
    chk("R1 sda released", 16'(sda_pull), 16'd0);
    s0 = strobes;
    read_reg(1'b0, 2'b00, 1'b1, d);
    chk("R1 default pointer reads temp", d, 16'h0000);
    chk("R11 one strobe per read", 16'(strobes - s0), 16'd1);

    // R5 R6 R8 write/read-back table
    for (int i = 0; i < 7; i++) begin
      logic [1:0] p;
      logic [15:0] exp;
      p = VEC[i][33:32]; exp = VEC[i][15:0];
      write_reg(p, VEC[i][31:16]);
      s0 = strobes;
      read_reg(1'b1, p, p != 2'b01, d);
      chk((p == 2'b01) ? "R5 cfg readback" : "R8 R6 limit readback", d, exp);
      chk("R11 strobe per table read", 16'(strobes - s0), 16'd1);
      if (p == 2'b01) chk("R5 cfg port", 16'(cfg_o), exp);
      else if (p == 2'b11) chk("R6 tos port", tos_o, exp);
      else chk("R6 thyst port", thyst_o, exp);
    end

    // R4 pointer-only write then read from stored pointer
    bus_start(); send_byte(AW, a); send_byte(8'h03, a); bus_stop();
    read_reg(1'b0, 2'b00, 1'b1, d);
    chk("R4 stored pointer read", d, 16'h8000);

    // R3 rejected pointers
    bus_start(); send_byte(AW, a); send_byte(8'h07, a); bus_stop();
    chk("R3 bad pointer nack", 16'(a), 16'd0);
    bus_start(); send_byte(AW, a); send_byte(8'h41, a); bus_stop();
    chk("R3 bad pointer nack high bit", 16'(a), 16'd0);
    read_reg(1'b0, 2'b00, 1'b1, d);
    chk("R3 pointer unchanged", d, 16'h8000);

    // R2 wrong address
    bus_start(); send_byte({4'b1001, 3'b010, 1'b0}, a); bus_stop();
    chk("R2 wrong address nack", 16'(a), 16'd0);
    bus_start(); send_byte({4'b1101, PINS, 1'b0}, a); bus_stop();
    chk("R2 wrong high bits nack", 16'(a), 16'd0);

    // R9 resolution scaling, all four codes
    load_sample(16'h1AB7);
    chk("R9 res 9 port", temp_o, 16'h1A80);
    read_reg(1'b1, 2'b00, 1'b1, d);
    chk("R9 res 9 bus read", d, 16'h1A80);
    write_reg(2'b01, 16'h0020); load_sample(16'h1AB7);
    chk("R9 res 10", temp_o, 16'h1A80);
    write_reg(2'b01, 16'h0040); load_sample(16'h1AB7);
    chk("R9 res 11", temp_o, 16'h1AA0);
    write_reg(2'b01, 16'h0060); load_sample(16'hE5FF);
    chk("R9 res 12", temp_o, 16'hE5F0);

    // R7 data write to the temperature word
    bus_start(); send_byte(AW, a); send_byte(8'h00, a);
    send_byte(8'h55, a); bus_stop();
    chk("R7 temp write nack", 16'(a), 16'd0);
    chk("R7 temp unchanged", temp_o, 16'hE5F0);

    // R10 sample during a temperature read
    begin
      logic [7:0] hi, lo;
      bus_start(); send_byte(AW, a); send_byte(8'h00, a); bus_start();
      send_byte(AR, a); recv_byte(1'b0, hi);
      load_sample(16'h0100);
      recv_byte(1'b1, lo); bus_stop();
      chk("R10 read data", {hi, lo}, 16'hE5F0);
      chk("R10 sample discarded", temp_o, 16'hE5F0);
      load_sample(16'h0107);
      chk("R10 next sample stored", temp_o, 16'h0100);
    end

    // R12 repeated start inside a limit write
    bus_start(); send_byte(AW, a); send_byte(8'h03, a); send_byte(8'h77, a);
    bus_start(); send_byte(AR, a);
    chk("R12 restart address ack", 16'(a), 16'd1);
    begin
      logic [7:0] hi, lo;
      recv_byte(1'b0, hi); recv_byte(1'b1, lo); bus_stop();
      chk("R12 partial write dropped", {hi, lo}, 16'h8000);
    end
    chk("R12 sda released after stop", 16'(sda_pull), 16'd0);

    // R8 config read is one byte
    s0 = strobes;
    read_reg(1'b1, 2'b01, 1'b0, d);
    chk("R8 cfg single byte", d, 16'h0060);
    chk("R11 strobe after cfg read", 16'(strobes - s0), 16'd1);

    wt(20);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule